// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This unit maintains the floating-point status word of a processor core. Each time an FP operation finishes, the sequencer raises a completion strobe together with a 5-bit vector of the IEEE exception conditions that the operation produced. The unit compares those conditions with the trap-enable mask held in the status word and makes three decisions:

- whether the operation traps;
- which single condition to report in the current-exception field when it does;
- whether the accrued-exception field is updated.

One clock later it presents the new status word. It also gives a one-cycle indication that tells the sequencer either to step the program counter past the instruction or to take the IEEE trap.

Software can load the whole status word through a write port. When a software write and a completion fall in the same cycle, the software value wins the register. The sequencer indication for that completion is still produced, and it is decided with the mask that was in force before the write.

Top module: `fp_exc_status`

## Requirements
- R1: While the synchronous active-high reset is held, the status word reads 0 and both `pcAdvance` and `trapTaken` read 0 on the following cycle.
- R2: A completion whose flags ANDed with the enable mask (status bits 27:23) give zero does not trap. On the next cycle:
  - bits 4:0 hold the raised flags;
  - bits 9:5 become their old value ORed with the flags;
  - bits 16:14 read 0;
  - `pcAdvance` is 1 and `trapTaken` is 0.
- R3: A completion whose flags share any set bit with the enable mask traps. On the next cycle `trapTaken` is 1, `pcAdvance` is 0, and bits 16:14 read 3'b001.
- R4: On a trap, bits 4:0 hold exactly one bit. That bit is the highest-priority bit of (flags AND mask). The flag bit order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0, and priority runs from bit 4 down to bit 0.
- R5: On a trap, the accrued field (bits 9:5) keeps its previous value.
- R6: A completion with all flags clear has these effects on the next cycle:
  - bits 4:0 are cleared;
  - the accrued field is unchanged;
  - `pcAdvance` is 1.
- R7: When `swWrEn` is high, the status word takes `swWrData` on the next edge, even if a completion is strobed in the same cycle. That completion still produces its `pcAdvance`/`trapTaken` pulse, decided with the enable mask held before the write.
- R8: In a cycle with no completion and no software write, the status word holds its value. On the next cycle `pcAdvance` and `trapTaken` are both 0.
- R9: A completion leaves every status bit outside 4:0, 9:5 and 16:14 unchanged, including the enable mask.
- R10: `pcAdvance` and `trapTaken` are never high together. One of them is high exactly in the cycle after each completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opDone | input | 1 | FP operation completion strobe |
| opFlags | input | 5 | Raised IEEE exception flags of the completing operation |
| swWrEn | input | 1 | Software write enable for the status word |
| swWrData | input | 32 | Software write value |
| statusOut | output | 32 | Current status word |
| pcAdvance | output | 1 | One-cycle pulse: step the program counter |
| trapTaken | output | 1 | One-cycle pulse: take the IEEE exception trap |

## Verification
On every cycle the checker enforces the following:
- the two sequencer outputs are mutually exclusive and pulse only after a strobe;
- a trapping completion leaves exactly one current-exception bit, an IEEE trap-type code and an unchanged accrued field;
- a software write lands verbatim;
- an idle cycle holds the word.

Which particular bit survives the priority reduction can be shown only by the bench's scenarios. They pair specific flag and mask combinations with the expected results, covering the ORing into a non-empty accrued field and the preservation of unrelated bits. The same holds for the collision case, where the old mask decides the trap while the written word is kept.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;
  // Width of an exception flag vector and of the status word
  parameter int FLAG_W = 5;
  parameter int STAT_W = 32;
  parameter int TT_W   = 3;

  // Field positions (software decodes these)
  parameter int CUR_LSB = 0;
  parameter int ACC_LSB = 5;
  parameter int TT_LSB  = 14;
  parameter int EN_LSB  = 23;

  // Trap-type code for an IEEE exception
  parameter logic [TT_W-1:0] TT_IEEE = 3'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadSw;
    logic              loadOp;
    logic              trap;
    logic [FLAG_W-1:0] curFlags;
  } statStrobe_t;
endpackage

// File: rtl/fp_exc_ctrl.sv
module fp_exc_ctrl
  import fp_exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              opDone,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic              swWrEn,
  input  logic [FLAG_W-1:0] enMask,
  output statStrobe_t       strobe,
  output logic              pcAdvance,
  output logic              trapTaken
);
  logic [FLAG_W-1:0] enabledHits;
  logic [FLAG_W-1:0] topHit;
  logic              trapNow;

  assign enabledHits = opFlags & enMask;
  assign trapNow     = opDone & (|enabledHits);

  // Keep only the highest set bit of enabledHits
  for (genvar i = 0; i < FLAG_W; i++) begin : g_pick
    if (i == FLAG_W - 1) begin : g_top
      assign topHit[i] = enabledHits[i];
    end else begin : g_rest
      assign topHit[i] = enabledHits[i] & ~(|enabledHits[FLAG_W-1:i+1]);
    end
  end

  always_comb begin
    strobe.loadSw   = swWrEn;
    strobe.loadOp   = opDone & ~swWrEn;
    strobe.trap     = trapNow;
    strobe.curFlags = trapNow ? topHit : opFlags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcAdvance <= 1'b0;
      trapTaken <= 1'b0;
    end else begin
      pcAdvance <= opDone & ~trapNow;
      trapTaken <= trapNow;
    end
  end
endmodule

// File: rtl/fp_exc_dp.sv
module fp_exc_dp
  import fp_exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  statStrobe_t       strobe,
  input  logic [STAT_W-1:0] swWrData,
  output logic [STAT_W-1:0] statusWord,
  output logic [FLAG_W-1:0] enMask
);
  logic [STAT_W-1:0] statReg;
  logic [STAT_W-1:0] opNext;
  logic [FLAG_W-1:0] accOld;

  assign accOld = statReg[ACC_LSB +: FLAG_W];

  always_comb begin
    opNext = statReg;
    opNext[CUR_LSB +: FLAG_W] = strobe.curFlags;
    opNext[TT_LSB +: TT_W]    = strobe.trap ? TT_IEEE : '0;
    if (!strobe.trap) begin
      opNext[ACC_LSB +: FLAG_W] = accOld | strobe.curFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statReg <= '0;
    end else if (strobe.loadSw) begin
      statReg <= swWrData;
    end else if (strobe.loadOp) begin
      statReg <= opNext;
    end
  end

  assign statusWord = statReg;
  assign enMask     = statReg[EN_LSB +: FLAG_W];
endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
  import fp_exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              opDone,
  input  logic [FLAG_W-1:0] opFlags,
  input  logic              swWrEn,
  input  logic [STAT_W-1:0] swWrData,
  output logic [STAT_W-1:0] statusOut,
  output logic              pcAdvance,
  output logic              trapTaken
);
  statStrobe_t       strobe;
  logic [FLAG_W-1:0] enMask;

  fp_exc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .opDone    (opDone),
    .opFlags   (opFlags),
    .swWrEn    (swWrEn),
    .enMask    (enMask),
    .strobe    (strobe),
    .pcAdvance (pcAdvance),
    .trapTaken (trapTaken)
  );

  fp_exc_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .swWrData   (swWrData),
    .statusWord (statusOut),
    .enMask     (enMask)
  );
endmodule

// File: rtl/fp_exc_status_chk.sv
module fp_exc_status_chk
  import fp_exc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              opDone,
  input logic [FLAG_W-1:0] opFlags,
  input logic              swWrEn,
  input logic [STAT_W-1:0] swWrData,
  input logic [STAT_W-1:0] statusOut,
  input logic              pcAdvance,
  input logic              trapTaken
);
  // R10
  out_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pcAdvance && trapTaken));

  // R10
  pulse_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    opDone |=> (pcAdvance || trapTaken));

  // R8
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !opDone |=> !(pcAdvance || trapTaken));

  // R4
  trap_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (trapTaken && !$past(swWrEn)) |-> ($countones(statusOut[CUR_LSB +: FLAG_W]) == 1));

  // R5
  trap_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trapTaken && !$past(swWrEn)) |->
      (statusOut[ACC_LSB +: FLAG_W] == $past(statusOut[ACC_LSB +: FLAG_W])));

  // R3
  trap_type_chk: assert property (@(posedge clk) disable iff (rst)
    (trapTaken && !$past(swWrEn)) |-> (statusOut[TT_LSB +: TT_W] == TT_IEEE));

  // R2
  adv_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (pcAdvance && !$past(swWrEn)) |-> (statusOut[CUR_LSB +: FLAG_W] == $past(opFlags)));

  // R7
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    (swWrEn && !opDone) |=> (statusOut == $past(swWrData)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!opDone && !swWrEn) |=> $stable(statusOut));
endmodule

bind fp_exc_status fp_exc_status_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .opDone    (opDone),
  .opFlags   (opFlags),
  .swWrEn    (swWrEn),
  .swWrData  (swWrData),
  .statusOut (statusOut),
  .pcAdvance (pcAdvance),
  .trapTaken (trapTaken)
);

// File: tb/tb_fp_exc_status.sv
module tb_fp_exc_status;
  logic        clk = 1'b0;
  logic        rst;
  logic        opDone;
  logic [4:0]  opFlags;
  logic        swWrEn;
  logic [31:0] swWrData;
  logic [31:0] statusOut;
  logic        pcAdvance;
  logic        trapTaken;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fp_exc_status dut (
    .clk(clk), .rst(rst), .opDone(opDone), .opFlags(opFlags),
    .swWrEn(swWrEn), .swWrData(swWrData), .statusOut(statusOut),
    .pcAdvance(pcAdvance), .trapTaken(trapTaken)
  );

  // {mask, accrued before, flags, expected current, expected accrued, expected trap}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 5'b00001, 5'b00001, 5'b00001, 1'b0},
    {5'b00000, 5'b00100, 5'b10010, 5'b10010, 5'b10110, 1'b0},
    {5'b11111, 5'b00000, 5'b11000, 5'b10000, 5'b00000, 1'b1},
    {5'b01111, 5'b00011, 5'b11000, 5'b01000, 5'b00011, 1'b1},
    {5'b00110, 5'b00000, 5'b00111, 5'b00100, 5'b00000, 1'b1},
    {5'b00001, 5'b00000, 5'b11110, 5'b11110, 5'b11110, 1'b0},
    {5'b00011, 5'b10000, 5'b00011, 5'b00010, 5'b10000, 1'b1},
    {5'b11111, 5'b01010, 5'b00000, 5'b00000, 5'b01010, 1'b0},
    {5'b00001, 5'b00000, 5'b00001, 5'b00001, 5'b00000, 1'b1},
    {5'b10000, 5'b00001, 5'b10101, 5'b10000, 5'b00001, 1'b1}
  };

  localparam logic [31:0 ] OTHER_BITS = 32'h8000_1000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic swWrite(input logic [31:0] d);
    @(negedge clk);
    swWrEn = 1'b1; swWrData = d;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  task automatic complete(input logic [4:0] f);
    @(negedge clk);
    opDone = 1'b1; opFlags = f;
    @(negedge clk);
    opDone = 1'b0; opFlags = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; opDone = 1'b0; opFlags = '0; swWrEn = 1'b0; swWrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", statusOut, 32'h0);
    check("R1 pcAdvance", {31'b0, pcAdvance}, 32'h0);
    check("R1 trapTaken", {31'b0, trapTaken}, 32'h0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      logic [4:0] m, a, f, ec, ea;
      logic et;
      logic [31:0] pre, exp;
      {m, a, f, ec, ea, et} = VEC[v];
      pre = OTHER_BITS | ({27'b0, m} << 23) | ({27'b0, a} << 5) | 32'h1f | (32'h7 << 14);
      exp = OTHER_BITS | ({27'b0, m} << 23) | ({27'b0, ea} << 5) | {27'b0, ec}
            | ({31'b0, et} << 14);
      swWrite(pre);
      complete(f);
      check(et ? "R3/R4/R5/R9 status after trap" : "R2/R6/R9 status after completion",
            statusOut, exp);
      check(et ? "R3 pcAdvance" : "R2 pcAdvance", {31'b0, pcAdvance}, {31'b0, ~et});
      check(et ? "R3 trapTaken" : "R2 trapTaken", {31'b0, trapTaken}, {31'b0, et});
    end

    // R8: idle cycles hold status and keep outputs low
    begin
      logic [31:0] held;
      held = statusOut;
      repeat (4) @(negedge clk);
      check("R8 status hold", statusOut, held);
      check("R8 pcAdvance idle", {31'b0, pcAdvance}, 32'h0);
      check("R8 trapTaken idle", {31'b0, trapTaken}, 32'h0);
    end

    // R7: write and trapping completion in same cycle; old mask decides trap
    swWrite(32'h0F80_0000);           // mask = 11111
    @(negedge clk);
    opDone = 1'b1; opFlags = 5'b00001;
    swWrEn = 1'b1; swWrData = 32'h0000_0123;
    @(negedge clk);
    opDone = 1'b0; opFlags = '0; swWrEn = 1'b0;
    check("R7 written word wins", statusOut, 32'h0000_0123);
    check("R7 trap from old mask", {31'b0, trapTaken}, 32'h1);
    check("R7 no advance", {31'b0, pcAdvance}, 32'h0);
    @(negedge clk);
    // R10 pulse lasts one cycle
    check("R10 trap pulse ends", {31'b0, trapTaken}, 32'h0);
    check("R10 advance stays low", {31'b0, pcAdvance}, 32'h0);

    // R7: write and non-trapping completion same cycle
    @(negedge clk);
    opDone = 1'b1; opFlags = 5'b00100;
    swWrEn = 1'b1; swWrData = 32'h0F80_0000;
    @(negedge clk);
    opDone = 1'b0; opFlags = '0; swWrEn = 1'b0;
    check("R7 written word wins (no trap)", statusOut, 32'h0F80_0000);
    check("R7 advance from old mask", {31'b0, pcAdvance}, 32'h1);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 status after reset", statusOut, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule